// File: doc/BRIEF.md
# Test Pattern Source Settings Register Bank

This block is the software-visible control and status register bank for a video test pattern source. A 32-bit single-cycle port lets software read identification and build-parameter words, write the image geometry, interlace code, pattern selection, bar style and three constant color planes, start and stop generation, and watch busy and pending flags.

Settings are double-buffered. A write lands only in a shadow copy, which is what software reads back. The pattern datapath sees a separate active copy. A write to the commit word arms a transfer. The whole shadow set is copied into the active set, in one cycle, on the next field-boundary strobe from the generator. Until that copy happens a pending flag stays visible in the status word, so software can tell when its changes have reached the pixels. The go bit is not shadowed and acts at once.

Top module: `tpg_csr_bank`

## Requirements
- R1: Offset 0x0000 reads 0x6AF70236, with vendor 0x6AF7 in bits 31:16 and product 0x0236 in bits 15:0. Offset 0x0004 reads the REV_WORD parameter (default 0x00010000), 0x0010 the NUM_CFG parameter (default 4), 0x0018 the BPS parameter (default 10) and 0x001C the PIX_PAR parameter (default 2).
- R2: After reset, the go output, every active setting, every readable setting word and the status word are zero. A write to the control word (0x0148) drives `act_go` from data bit 0 in the next cycle, without waiting for a commit, and the control word reads back that bit.
- R3: Any write to 0x0120, 0x0124, 0x0128, 0x0148, 0x014C, 0x0150, 0x0154, 0x015C, 0x0160, 0x0164 or 0x0168 sets status bit 1 (pending) in the next cycle.
- R4: A write to the commit word 0x014C arms a transfer, whatever the data. Pending and the arm both clear at the next field-boundary strobe. The commit word reads as zero.
- R5: The active settings change only in the cycle after a field-boundary strobe that arrives while a commit is armed. In that cycle they take the whole shadow set (width, height, interlace, pattern, bar style, C0 to C2) at once.
- R6: Status bit 0 returns the `field_active` input as sampled in the read cycle.
- R7: Width (0x0120) and height (0x0124) keep data bits 15:0. Interlace (0x0128) keeps bits 3:0, pattern select (0x0150) bits 2:0 and bar style (0x0168) bits 1:0. C0, C1 and C2 (0x015C, 0x0160, 0x0164) keep bits BPS-1:0 (9:0 by default). Bits above these read as zero.
- R8: Unmapped, reserved and misaligned offsets read zero. Writes to them change no setting and leave pending unchanged. The one exception is 0x0154, which sets pending (R3) and stores nothing.
- R9: Read data is registered. It appears the cycle after `csr_rd` and holds its value while `csr_rd` is low.
- R10: A setting write in the same cycle as a committing strobe goes into the shadow set only, and pending stays set. A commit written in the cycle of a strobe while nothing is armed is applied at the following strobe, not at this one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 16 | Byte address of the access |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rd | input | 1 | Read strobe |
| csr_rdata | output | 32 | Registered read data |
| field_boundary | input | 1 | One-cycle strobe from the generator marking a field boundary |
| field_active | input | 1 | High while the generator is producing a field |
| act_go | output | 1 | Go control to the generator |
| act_width | output | 16 | Active field width |
| act_height | output | 16 | Active frame height |
| act_ilace | output | 4 | Active interlace code |
| act_pattern | output | 3 | Active pattern configuration index |
| act_bars | output | 2 | Active bar style |
| act_c0 | output | BPS | Active constant color plane 0 |
| act_c1 | output | BPS | Active constant color plane 1 |
| act_c2 | output | BPS | Active constant color plane 2 |

## Verification
A stuck or lost arm flag shows up at the active outputs on the very next field-boundary strobe: they either fail to take the committed values or take them with no commit. A pending flag that is wrong shows in the first status read after the write or after the strobe. A shadow register that is decoded wrongly or masked wrongly shows in the read-back one cycle after the read. It also shows at the active outputs one cycle after the committing strobe. The bench checks every boundary case in the cycle right after the event, so a fault does not have time to hide behind later traffic.

// File: rtl/tpg_csr_pkg.sv
package tpg_csr_pkg;

  localparam logic [31:0] ID_WORD = 32'h6AF7_0236;

  localparam logic [15:0] OFF_ID     = 16'h0000;
  localparam logic [15:0] OFF_REV    = 16'h0004;
  localparam logic [15:0] OFF_NCFG   = 16'h0010;
  localparam logic [15:0] OFF_BPS    = 16'h0018;
  localparam logic [15:0] OFF_PIP    = 16'h001C;
  localparam logic [15:0] OFF_WIDTH  = 16'h0120;
  localparam logic [15:0] OFF_HEIGHT = 16'h0124;
  localparam logic [15:0] OFF_ILACE  = 16'h0128;
  localparam logic [15:0] OFF_STATUS = 16'h0140;
  localparam logic [15:0] OFF_CTRL   = 16'h0148;
  localparam logic [15:0] OFF_COMMIT = 16'h014C;
  localparam logic [15:0] OFF_PATSEL = 16'h0150;
  localparam logic [15:0] OFF_RSVD   = 16'h0154;
  localparam logic [15:0] OFF_C0     = 16'h015C;
  localparam logic [15:0] OFF_C1     = 16'h0160;
  localparam logic [15:0] OFF_C2     = 16'h0164;
  localparam logic [15:0] OFF_BARS   = 16'h0168;

  // bit positions of the one-hot write strobe vector
  localparam int W_WIDTH  = 0;
  localparam int W_HEIGHT = 1;
  localparam int W_ILACE  = 2;
  localparam int W_CTRL   = 3;
  localparam int W_COMMIT = 4;
  localparam int W_PATSEL = 5;
  localparam int W_RSVD   = 6;
  localparam int W_C0     = 7;
  localparam int W_C1     = 8;
  localparam int W_C2     = 9;
  localparam int W_BARS   = 10;
  localparam int NUM_WSEL = 11;

  localparam int NUM_PLANES = 3;

  typedef struct packed {
    logic [15:0] width;
    logic [15:0] height;
    logic [3:0]  ilace;
    logic [2:0]  pattern;
    logic [1:0]  bars;
  } img_cfg_t;

endpackage

// File: rtl/tpg_csr_decode.sv
module tpg_csr_decode
  import tpg_csr_pkg::*;
(
  input  logic [15:0]         csr_addr,
  input  logic                csr_wr,
  output logic [NUM_WSEL-1:0] wr_vec,
  output logic                wr_setting
);

  always_comb begin
    wr_vec = '0;
    if (csr_wr) begin
      case (csr_addr)
        OFF_WIDTH:  wr_vec[W_WIDTH]  = 1'b1;
        OFF_HEIGHT: wr_vec[W_HEIGHT] = 1'b1;
        OFF_ILACE:  wr_vec[W_ILACE]  = 1'b1;
        OFF_CTRL:   wr_vec[W_CTRL]   = 1'b1;
        OFF_COMMIT: wr_vec[W_COMMIT] = 1'b1;
        OFF_PATSEL: wr_vec[W_PATSEL] = 1'b1;
        OFF_RSVD:   wr_vec[W_RSVD]   = 1'b1;
        OFF_C0:     wr_vec[W_C0]     = 1'b1;
        OFF_C1:     wr_vec[W_C1]     = 1'b1;
        OFF_C2:     wr_vec[W_C2]     = 1'b1;
        OFF_BARS:   wr_vec[W_BARS]   = 1'b1;
        default:    wr_vec = '0;
      endcase
    end
  end

  assign wr_setting = |wr_vec;

endmodule

// File: rtl/tpg_csr_commit.sv
module tpg_csr_commit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_setting,
  input  logic wr_commit,
  input  logic field_boundary,
  output logic pending,
  output logic armed,
  output logic load
);

  logic pend_q, pend_n;
  logic arm_q, arm_n;

  assign load = arm_q & field_boundary;

  always_comb begin
    pend_n = pend_q;
    arm_n  = arm_q;
    if (load) begin
      pend_n = 1'b0;
      arm_n  = 1'b0;
    end
    if (wr_setting) pend_n = 1'b1;
    if (wr_commit)  arm_n  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      arm_q  <= arm_n;
    end
  end

  assign pending = pend_q;
  assign armed   = arm_q;

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_setting |=> pending); // R3
  AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && field_boundary && !wr_setting) |=> !pending); // R4
  AST_ARM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !field_boundary) |=> armed); // R4

endmodule

// File: rtl/tpg_csr_shadow.sv
module tpg_csr_shadow
  import tpg_csr_pkg::*;
#(
  parameter int BPS = 10
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_WSEL-1:0]              wr_vec,
  input  logic [15:0]                      wdata,
  input  logic                             load,
  output img_cfg_t                         shd_cfg,
  output img_cfg_t                         act_cfg,
  output logic [NUM_PLANES-1:0][BPS-1:0]   shd_color,
  output logic [NUM_PLANES-1:0][BPS-1:0]   act_color
);

  img_cfg_t shd_q, shd_n, act_q, act_n;

  always_comb begin
    shd_n = shd_q;
    if (wr_vec[W_WIDTH])  shd_n.width   = wdata;
    if (wr_vec[W_HEIGHT]) shd_n.height  = wdata;
    if (wr_vec[W_ILACE])  shd_n.ilace   = wdata[3:0];
    if (wr_vec[W_PATSEL]) shd_n.pattern = wdata[2:0];
    if (wr_vec[W_BARS])   shd_n.bars    = wdata[1:0];
    act_n = load ? shd_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      shd_q <= shd_n;
      act_q <= act_n;
    end
  end

  assign shd_cfg = shd_q;
  assign act_cfg = act_q;

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    logic [BPS-1:0] cs_q, cs_n, ca_q, ca_n;
    assign cs_n = wr_vec[W_C0 + p] ? wdata[BPS-1:0] : cs_q;
    assign ca_n = load ? cs_q : ca_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cs_q <= '0;
        ca_q <= '0;
      end else begin
        cs_q <= cs_n;
        ca_q <= ca_n;
      end
    end
    assign shd_color[p] = cs_q;
    assign act_color[p] = ca_q;

    AST_COLOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(act_color[p])); // R5
  end

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_cfg)); // R5
  AST_ACT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (act_cfg == $past(shd_cfg))); // R5

endmodule

// File: rtl/tpg_csr_bank.sv
module tpg_csr_bank
  import tpg_csr_pkg::*;
#(
  parameter int          BPS      = 10,
  parameter int          PIX_PAR  = 2,
  parameter int          NUM_CFG  = 4,
  parameter logic [31:0] REV_WORD = 32'h0001_0000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [15:0]    csr_addr,
  input  logic           csr_wr,
  input  logic [31:0]    csr_wdata,
  input  logic           csr_rd,
  output logic [31:0]    csr_rdata,
  input  logic           field_boundary,
  input  logic           field_active,
  output logic           act_go,
  output logic [15:0]    act_width,
  output logic [15:0]    act_height,
  output logic [3:0]     act_ilace,
  output logic [2:0]     act_pattern,
  output logic [1:0]     act_bars,
  output logic [BPS-1:0] act_c0,
  output logic [BPS-1:0] act_c1,
  output logic [BPS-1:0] act_c2
);

  localparam int PAD = 32 - BPS;

  logic [NUM_WSEL-1:0]            wr_vec;
  logic                           wr_setting;
  logic                           pending, armed, load;
  img_cfg_t                       shd_cfg, act_cfg;
  logic [NUM_PLANES-1:0][BPS-1:0] shd_color, act_color;
  logic                           go_q, go_n;
  logic [31:0]                    rdata_q, rdata_n;
  logic                           unused_wdata;

  assign unused_wdata = ^{csr_wdata[31:16], armed};

  tpg_csr_decode u_decode (
    .csr_addr   (csr_addr),
    .csr_wr     (csr_wr),
    .wr_vec     (wr_vec),
    .wr_setting (wr_setting)
  );

  tpg_csr_commit u_commit (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_setting     (wr_setting),
    .wr_commit      (wr_vec[W_COMMIT]),
    .field_boundary (field_boundary),
    .pending        (pending),
    .armed          (armed),
    .load           (load)
  );

  tpg_csr_shadow #(.BPS(BPS)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_vec    (wr_vec),
    .wdata     (csr_wdata[15:0]),
    .load      (load),
    .shd_cfg   (shd_cfg),
    .act_cfg   (act_cfg),
    .shd_color (shd_color),
    .act_color (act_color)
  );

  // go bit acts immediately, outside the double buffer
  assign go_n = wr_vec[W_CTRL] ? csr_wdata[0] : go_q;

  always_comb begin
    case (csr_addr)
      OFF_ID:     rdata_n = ID_WORD;
      OFF_REV:    rdata_n = REV_WORD;
      OFF_NCFG:   rdata_n = 32'(NUM_CFG);
      OFF_BPS:    rdata_n = 32'(BPS);
      OFF_PIP:    rdata_n = 32'(PIX_PAR);
      OFF_WIDTH:  rdata_n = {16'h0, shd_cfg.width};
      OFF_HEIGHT: rdata_n = {16'h0, shd_cfg.height};
      OFF_ILACE:  rdata_n = {28'h0, shd_cfg.ilace};
      OFF_STATUS: rdata_n = {30'h0, pending, field_active};
      OFF_CTRL:   rdata_n = {31'h0, go_q};
      OFF_PATSEL: rdata_n = {29'h0, shd_cfg.pattern};
      OFF_C0:     rdata_n = {{PAD{1'b0}}, shd_color[0]};
      OFF_C1:     rdata_n = {{PAD{1'b0}}, shd_color[1]};
      OFF_C2:     rdata_n = {{PAD{1'b0}}, shd_color[2]};
      OFF_BARS:   rdata_n = {30'h0, shd_cfg.bars};
      default:    rdata_n = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      go_q <= go_n;
      if (csr_rd) rdata_q <= rdata_n;
    end
  end

  assign csr_rdata   = rdata_q;
  assign act_go      = go_q;
  assign act_width   = act_cfg.width;
  assign act_height  = act_cfg.height;
  assign act_ilace   = act_cfg.ilace;
  assign act_pattern = act_cfg.pattern;
  assign act_bars    = act_cfg.bars;
  assign act_c0      = act_color[0];
  assign act_c1      = act_color[1];
  assign act_c2      = act_color[2];

  AST_ID_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && csr_addr == OFF_ID) |=> (csr_rdata == 32'h6AF7_0236)); // R1
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rd |=> $stable(csr_rdata)); // R9
  AST_GO_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_addr == OFF_CTRL) |=> (act_go == $past(csr_wdata[0]))); // R2
  AST_STATUS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && csr_addr == OFF_STATUS) |=> (csr_rdata[0] == $past(field_active))); // R6

endmodule

// File: tb/tpg_csr_bank_test.sv
`timescale 1ns/1ps
module tpg_csr_bank_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] csr_addr;
  logic        csr_wr, csr_rd;
  logic [31:0] csr_wdata, csr_rdata;
  logic        field_boundary, field_active;
  logic        act_go;
  logic [15:0] act_width, act_height;
  logic [3:0]  act_ilace;
  logic [2:0]  act_pattern;
  logic [1:0]  act_bars;
  logic [9:0]  act_c0, act_c1, act_c2;

  int checks = 0;
  int errors = 0;

  typedef struct {
    string       tag;
    logic [15:0] addr;
    logic [31:0] exp;
  } exp_t;
  exp_t sbq[$];

  always #4 clk = ~clk;

  tpg_csr_bank uut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .csr_rd(csr_rd), .csr_rdata(csr_rdata),
    .field_boundary(field_boundary), .field_active(field_active),
    .act_go(act_go), .act_width(act_width), .act_height(act_height),
    .act_ilace(act_ilace), .act_pattern(act_pattern), .act_bars(act_bars),
    .act_c0(act_c0), .act_c1(act_c1), .act_c2(act_c2)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(bit w, bit r, logic [15:0] a, logic [31:0] d, bit b);
    @(negedge clk);
    csr_wr = w; csr_rd = r; csr_addr = a; csr_wdata = d; field_boundary = b;
    @(negedge clk);
    csr_wr = 1'b0; csr_rd = 1'b0; field_boundary = 1'b0;
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    step(1'b1, 1'b0, a, d, 1'b0);
  endtask

  task automatic bnd();
    step(1'b0, 1'b0, 16'h0, 32'h0, 1'b1);
  endtask

  task automatic rd(string tag, logic [15:0] a, logic [31:0] exp);
    exp_t e;
    e.tag = tag; e.addr = a; e.exp = exp;
    sbq.push_back(e);
    step(1'b0, 1'b1, a, 32'h0, 1'b0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // monitor: compares registered read data against the scoreboard queue
  initial begin
    forever begin
      @(posedge clk);
      if (csr_rd) begin
        exp_t e;
        @(negedge clk);
        if (sbq.size() == 0) begin
          check("R9 unexpected read", csr_rdata, 32'hx);
        end else begin
          e = sbq.pop_front();
          check(e.tag, csr_rdata, e.exp);
        end
      end
    end
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; csr_addr = '0; csr_wr = 1'b0; csr_rd = 1'b0;
    csr_wdata = '0; field_boundary = 1'b0; field_active = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    check("R2 go after reset", {31'h0, act_go}, 32'h0);
    check("R2 width after reset", {16'h0, act_width}, 32'h0);
    rd("R2 status after reset", 16'h0140, 32'h0);
    rd("R2 width word after reset", 16'h0120, 32'h0);

    // identification and parameter words
    rd("R1 id word", 16'h0000, 32'h6AF7_0236);
    rd("R1 revision", 16'h0004, 32'h0001_0000);
    rd("R1 num configs", 16'h0010, 32'd4);
    rd("R1 bps", 16'h0018, 32'd10);
    rd("R1 pixels in parallel", 16'h001C, 32'd2);
    repeat (3) step(1'b0, 1'b0, 16'h0, 32'h0, 1'b0);
    check("R9 read data held", csr_rdata, 32'd2);

    // shadow writes with masking
    wr(16'h0120, 32'hABCD_1280);
    rd("R3 pending after width write", 16'h0140, 32'h2);
    rd("R7 width masked", 16'h0120, 32'h0000_1280);
    wr(16'h0124, 32'h000F_0438);
    wr(16'h0128, 32'h0000_00FF);
    wr(16'h0150, 32'h0000_00FE);
    wr(16'h015C, 32'h0000_FFFF);
    wr(16'h0160, 32'h0000_0155);
    wr(16'h0164, 32'h0000_1200);
    wr(16'h0168, 32'h0000_0007);
    rd("R7 height masked", 16'h0124, 32'h0000_0438);
    rd("R7 interlace masked", 16'h0128, 32'h0000_000F);
    rd("R7 pattern masked", 16'h0150, 32'h0000_0006);
    rd("R7 c0 masked", 16'h015C, 32'h0000_03FF);
    rd("R7 c2 masked", 16'h0164, 32'h0000_0200);
    rd("R7 bars masked", 16'h0168, 32'h0000_0003);
    check("R5 active unchanged before commit", {16'h0, act_width}, 32'h0);

    // strobe without commit does nothing
    bnd();
    check("R5 no load without commit", {16'h0, act_width}, 32'h0);
    check("R5 pattern without commit", {29'h0, act_pattern}, 32'h0);
    rd("R4 pending kept without commit", 16'h0140, 32'h2);

    // commit then strobe
    wr(16'h014C, 32'h0000_DEAD);
    rd("R4 commit reads zero", 16'h014C, 32'h0);
    check("R5 commit alone does not load", {16'h0, act_width}, 32'h0);
    bnd();
    check("R5 width loaded", {16'h0, act_width}, 32'h1280);
    check("R5 height loaded", {16'h0, act_height}, 32'h0438);
    check("R5 interlace loaded", {28'h0, act_ilace}, 32'hF);
    check("R5 pattern loaded", {29'h0, act_pattern}, 32'h6);
    check("R5 bars loaded", {30'h0, act_bars}, 32'h3);
    check("R5 c0 loaded", {22'h0, act_c0}, 32'h3FF);
    check("R5 c1 loaded", {22'h0, act_c1}, 32'h155);
    check("R5 c2 loaded", {22'h0, act_c2}, 32'h200);
    rd("R4 pending cleared at boundary", 16'h0140, 32'h0);

    // arm is consumed by one boundary
    wr(16'h0120, 32'h0000_0500);
    bnd();
    check("R5 arm consumed", {16'h0, act_width}, 32'h1280);

    // busy bit
    field_active = 1'b1;
    rd("R6 busy and pending", 16'h0140, 32'h3);
    field_active = 1'b0;
    rd("R6 idle and pending", 16'h0140, 32'h2);

    wr(16'h014C, 32'h0);
    bnd();
    check("R5 second commit", {16'h0, act_width}, 32'h0500);

    // unmapped and reserved
    wr(16'h0200, 32'h1234_5678);
    wr(16'h0158, 32'hFFFF_FFFF);
    wr(16'h0122, 32'h0000_0999);
    rd("R8 unmapped writes leave pending clear", 16'h0140, 32'h0);
    rd("R8 unmapped reads zero", 16'h0200, 32'h0);
    rd("R8 reserved reads zero", 16'h0158, 32'h0);
    rd("R8 width untouched", 16'h0120, 32'h0000_0500);
    wr(16'h0154, 32'h0000_0001);
    rd("R3 reserved slot sets pending", 16'h0140, 32'h2);
    rd("R8 reserved slot reads zero", 16'h0154, 32'h0);

    // go bit
    wr(16'h0148, 32'h0000_0003);
    check("R2 go set immediately", {31'h0, act_go}, 32'h1);
    rd("R2 control readback", 16'h0148, 32'h1);
    wr(16'h0148, 32'h0);
    check("R2 go cleared", {31'h0, act_go}, 32'h0);

    // same-cycle priorities
    wr(16'h0120, 32'h0000_0600);
    wr(16'h014C, 32'h0);
    step(1'b1, 1'b0, 16'h0120, 32'h0000_0777, 1'b1);
    check("R10 load uses prior shadow", {16'h0, act_width}, 32'h0600);
    rd("R10 pending kept by same-cycle write", 16'h0140, 32'h2);
    rd("R10 shadow took late write", 16'h0120, 32'h0000_0777);
    bnd();
    check("R10 late write not loaded", {16'h0, act_width}, 32'h0600);
    step(1'b1, 1'b0, 16'h014C, 32'h0, 1'b1);
    check("R10 commit on strobe not applied", {16'h0, act_width}, 32'h0600);
    bnd();
    check("R10 commit applied at next strobe", {16'h0, act_width}, 32'h0777);
    rd("R4 pending clear at end", 16'h0140, 32'h0);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule